// File: doc/BRIEF.md
# Nibble-Written Character Bank Mapper

This block holds eight 1 KB character-bank registers for the pattern-memory side of a cartridge. The CPU builds each register four bits at a time. A decoded address picks the slot and says which half of the slot's low byte is written. The PPU's address bits 12:10 choose one of eight 1 KB windows. The block looks up that window's bank number combinationally and drives it to the external character ROM.

Two low-byte codes, 4 and 5, are treated differently. While the lock flag is clear, a window whose low byte holds either code is sent to a small 2 KB on-cartridge character RAM instead of the ROM. The lock flag is set or cleared when slot 0's low byte takes one of two particular values. Setting it turns that RAM substitution off.

Top module: `chr_nibble_mapper`

## Requirements
- R1: A slot changes only on a clock edge where cpu_we is 1 and cpu_addr lies between 0xB000 and 0xE00C inclusive. Any other write, and any cycle with cpu_we at 0, leaves every slot and the lock flag unchanged.
- R2: Address bits 15:12 pick a slot pair: 0xB gives slots 0/1, 0xC gives 2/3, 0xD gives 4/5 and 0xE gives 6/7. The odd slot of the pair is taken when address bit 3 or address bit 11 is 1.
- R3: With address bit 2 at 0, cpu_wdata[3:0] replaces bits 3:0 of the slot's low byte. Bits 7:4 of the low byte and the slot's high bits keep their values.
- R4: With address bit 2 at 1, cpu_wdata[3:0] replaces bits 7:4 of the slot's low byte. cpu_wdata[4] (with the default HI_W of 1) becomes the slot's high bit, and bits 3:0 of the low byte keep their value.
- R5: A slot's bank number is its high bit(s) placed above its 8-bit low byte, which gives 9 bits by default. rom_bank always shows the bank number of the window that ppu_a selects.
- R6: After a write to slot 0, the lock flag is set if the new low byte is 0x88 and cleared if it is 0xC8. Any other value leaves the flag as it was. Writes to other slots never change it.
- R7: While the lock flag is clear, a window whose low byte is 4 or 5 drives ram_sel to 1, and ram_page equals bit 0 of its bank number.
- R8: In every other case ram_sel is 0. The lookup follows ppu_a in the same cycle, with no register on the way.
- R9: Reset (rst_n low) clears every slot and the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_a | input | 3 | PPU address bits 12:10, window index |
| rom_bank | output | 9 | Bank number of the selected window |
| ram_sel | output | 1 | Window is served by on-cartridge RAM |
| ram_page | output | 1 | 1 KB RAM page when ram_sel is 1 |

## Verification
Some properties are checked by assertions on every cycle. Slots hold their value when there is no accepted write. A low-half write leaves the upper nibble and the high bits alone, and an upper-half write leaves the lower nibble alone. The lock flag moves only on a write to slot 0, and it always follows the two magic values. While the flag is set, ram_sel never rises. Other behaviour shows up only in the bench's scenarios, which compare every cycle against a behavioural model. These cover the exact slot each address reaches, including the folding of bit 11 into the odd-slot choice, and the inclusive edge at 0xE00C against addresses just past it. They also cover building a magic value across two nibble writes, and RAM substitution returning once the flag is cleared.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  localparam logic [15:0] WIN_FIRST = 16'hB000;
  localparam logic [15:0] WIN_LAST  = 16'hE00C;
  localparam logic [7:0]  CODE_LOCK   = 8'h88;
  localparam logic [7:0]  CODE_UNLOCK = 8'hC8;

  // merge a nibble into one half of a byte
  function automatic logic [7:0] merge_nib(input logic [7:0] old_b,
                                           input logic [3:0] nib,
                                           input logic upper);
    return upper ? {nib, old_b[3:0]} : {old_b[7:4], nib};
  endfunction

  // slot index: pair from bits 13:12 (B->0 .. E->3), odd from bit 3 or bit 11
  function automatic logic [2:0] slot_of(input logic [15:0] a);
    logic [1:0] pair;
    pair = a[13:12] + 2'd1;
    return {pair, a[11] | a[3]};
  endfunction

  // low-byte codes that divert a window to on-board RAM
  function automatic logic is_ram_code(input logic [7:0] lo);
    return lo[7:1] == 7'b0000010;
  endfunction

endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
  import chr_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output logic              upper
);
  logic in_win;
  logic [15:0] a16;

  always_comb begin
    a16    = 16'(addr);
    in_win = (a16 >= WIN_FIRST) && (a16 <= WIN_LAST);
    hit    = we && in_win;
    slot   = SLOT_W'(slot_of(a16));
    upper  = a16[2];
  end
endmodule

// File: rtl/chr_bank_file.sv
module chr_bank_file
  import chr_map_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 8,
  parameter int HI_W   = 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hit,
  input  logic [SLOT_W-1:0]           slot,
  input  logic                        upper,
  input  logic [DATA_W-1:0]           wdata,
  output logic [SLOTS-1:0][7:0]       lo_q,
  output logic [SLOTS-1:0][HI_W-1:0]  hi_q,
  output logic                        slot0_wr,
  output logic [7:0]                  slot0_new
);
  logic [SLOTS-1:0] slot_we;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [7:0] lo_d;

    always_comb begin
      slot_we[i] = hit && (slot == SLOT_W'(i));
      lo_d       = merge_nib(lo_q[i], wdata[3:0], upper);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (slot_we[i]) begin
        lo_q[i] <= lo_d;
        if (upper) hi_q[i] <= wdata[4 +: HI_W];
      end
    end

    // R1: without an accepted write the slot holds
    a_r1_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(lo_q[i]) && $stable(hi_q[i])));
    // R3: low-half write keeps upper nibble and high bits
    a_r3_low_write_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_we[i] && !upper) |=> ($stable(lo_q[i][7:4]) && $stable(hi_q[i])));
    // R4: upper-half write keeps lower nibble
    a_r4_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_we[i] && upper) |=> $stable(lo_q[i][3:0]));
  end

  always_comb begin
    slot0_wr  = slot_we[0];
    slot0_new = merge_nib(lo_q[0], wdata[3:0], upper);
  end
endmodule

// File: rtl/chr_lock_ctl.sv
module chr_lock_ctl
  import chr_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot0_wr,
  input  logic [7:0] slot0_new,
  output logic       lock
);
  logic lock_on_evt, lock_off_evt;

  always_comb begin
    lock_on_evt  = slot0_wr && (slot0_new == CODE_LOCK);
    lock_off_evt = slot0_wr && (slot0_new == CODE_UNLOCK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lock <= 1'b0;
    else if (lock_on_evt)  lock <= 1'b1;
    else if (lock_off_evt) lock <= 1'b0;
  end

  // R6: flag follows the magic codes and moves only on slot 0 writes
  a_r6_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on_evt |=> lock);
  a_r6_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lock_off_evt |=> !lock);
  a_r6_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !slot0_wr |=> $stable(lock));
endmodule

// File: rtl/chr_window_sel.sv
module chr_window_sel
  import chr_map_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int HI_W  = 1,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BANK_W = 8 + HI_W
) (
  input  logic [SLOT_W-1:0]          win,
  input  logic [SLOTS-1:0][7:0]      lo_q,
  input  logic [SLOTS-1:0][HI_W-1:0] hi_q,
  input  logic                       lock,
  output logic [BANK_W-1:0]          bank,
  output logic                       ram_sel,
  output logic                       ram_page
);
  logic [7:0]      sel_lo;
  logic [HI_W-1:0] sel_hi;

  always_comb begin
    sel_lo   = lo_q[win];
    sel_hi   = hi_q[win];
    bank     = {sel_hi, sel_lo};
    ram_sel  = !lock && is_ram_code(sel_lo);
    ram_page = bank[0];
  end
endmodule

// File: rtl/chr_nibble_mapper.sv
module chr_nibble_mapper #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = 1,
  parameter int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BANK_W = 8 + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [SLOT_W-1:0] ppu_a,
  output logic [BANK_W-1:0] rom_bank,
  output logic              ram_sel,
  output logic              ram_page
);
  logic                       wr_hit, wr_upper, slot0_wr, lock;
  logic [SLOT_W-1:0]          wr_slot;
  logic [7:0]                 slot0_new;
  logic [SLOTS-1:0][7:0]      lo_q;
  logic [SLOTS-1:0][HI_W-1:0] hi_q;

  chr_wr_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
    .we(cpu_we), .addr(cpu_addr), .hit(wr_hit), .slot(wr_slot), .upper(wr_upper));

  chr_bank_file #(.SLOTS(SLOTS), .DATA_W(DATA_W), .HI_W(HI_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .hit(wr_hit), .slot(wr_slot), .upper(wr_upper),
    .wdata(cpu_wdata), .lo_q(lo_q), .hi_q(hi_q),
    .slot0_wr(slot0_wr), .slot0_new(slot0_new));

  chr_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .slot0_wr(slot0_wr), .slot0_new(slot0_new), .lock(lock));

  chr_window_sel #(.SLOTS(SLOTS), .HI_W(HI_W)) u_sel (
    .win(ppu_a), .lo_q(lo_q), .hi_q(hi_q), .lock(lock),
    .bank(rom_bank), .ram_sel(ram_sel), .ram_page(ram_page));

  // R7: a set lock flag never lets a window reach the RAM
  a_r7_lock_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !ram_sel);
  // R1: a cycle without strobe cannot move the lock flag
  a_r1_no_strobe_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> $stable(lock));
endmodule

// File: tb/chr_nibble_mapper_test.sv
module chr_nibble_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [2:0]  ppu_a = 0;
  logic [8:0]  rom_bank;
  logic        ram_sel, ram_page;

  int checks = 0, errors = 0;
  int mlo[8], mhi[8];
  int mlock = 0;

  chr_nibble_mapper uut (.clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_a(ppu_a), .rom_bank(rom_bank), .ram_sel(ram_sel),
    .ram_page(ram_page));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int k = 0; k < 8; k++) begin mlo[k] = 0; mhi[k] = 0; end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin mlo[k] = 0; mhi[k] = 0; end
      mlock = 0;
    end else if (cpu_we && cpu_addr >= 16'hB000 && cpu_addr <= 16'hE00C) begin
      int s;
      int a;
      a = int'(cpu_addr);
      s = (a / 4096 - 11) * 2 + (((a & 8) != 0 || (a & 2048) != 0) ? 1 : 0);
      if ((a & 4) != 0) begin
        mlo[s] = (mlo[s] % 16) + (int'(cpu_wdata) % 16) * 16;
        mhi[s] = (int'(cpu_wdata) / 16) % 2;
      end else
        mlo[s] = (mlo[s] / 16) * 16 + int'(cpu_wdata) % 16;
      if (s == 0) begin
        if (mlo[0] == 200) mlock = 0;
        else if (mlo[0] == 136) mlock = 1;
      end
    end
  end

  function automatic int exp_bank(int w); return mhi[w] * 256 + mlo[w]; endfunction
  function automatic int exp_ram(int w); return ((mlo[w] == 4 || mlo[w] == 5) && mlock == 0) ? 1 : 0; endfunction

  // per-cycle comparison against the model (R5, R7, R8)
  always @(negedge clk) if (rst_n) begin
    int w;
    w = int'(ppu_a);
    checks++;
    if (int'(rom_bank) != exp_bank(w) || int'(ram_sel) != exp_ram(w) ||
        (exp_ram(w) == 1 && int'(ram_page) != mlo[w] % 2)) begin
      errors++;
      $display("FAIL R8 window %0d: actual bank=%0h ram=%0d page=%0d expected bank=%0h ram=%0d",
               w, rom_bank, ram_sel, ram_page, exp_bank(w), exp_ram(w));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic chk(input int w, input int eb, input int er, input int ep, input string tag);
    @(negedge clk); #2 ppu_a = 3'(w); #1;
    checks++;
    if (int'(rom_bank) != eb || int'(ram_sel) != er || (er == 1 && int'(ram_page) != ep)) begin
      errors++;
      $display("FAIL %s window %0d: actual bank=%0h ram=%0d page=%0d expected bank=%0h ram=%0d page=%0d",
               tag, w, rom_bank, ram_sel, ram_page, eb, er, ep);
    end
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 8; w++) chk(w, exp_bank(w), exp_ram(w), mlo[w] % 2, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    chk(3, 0, 0, 0, "R9");
    @(negedge clk); rst_n = 1;
    chk(0, 0, 0, 0, "R9");
    wr(16'hB000, 8'h37); chk(0, 'h007, 0, 0, "R3");
    wr(16'hB004, 8'h1A); chk(0, 'h1A7, 0, 0, "R4");
    wr(16'hB000, 8'h02); chk(0, 'h1A2, 0, 0, "R3");
    wr(16'hB800, 8'h05); chk(1, 'h005, 1, 1, "R2");
    wr(16'hE00C, 8'h13); chk(7, 'h130, 0, 0, "R1");
    wr(16'hE010, 8'h0F); chk(7, 'h130, 0, 0, "R1");
    wr(16'hAFFC, 8'h0F); chk(7, 'h130, 0, 0, "R1");
    @(negedge clk); cpu_addr = 16'hC000; cpu_wdata = 8'h09;
    @(negedge clk); chk(2, 0, 0, 0, "R1");
    wr(16'hC000, 8'h04); chk(2, 'h004, 1, 0, "R7");
    wr(16'hB808, 8'h08); wr(16'hB80C, 8'h08);
    chk(1, 'h088, 0, 0, "R2"); chk(2, 'h004, 1, 0, "R6");
    wr(16'hB800, 8'h05); chk(1, 'h085, 0, 0, "R3");
    wr(16'hB808, 8'h05); chk(1, 'h085, 0, 0, "R2");
    wr(16'hB80C, 8'h00); chk(1, 'h005, 1, 1, "R7");
    wr(16'hB000, 8'h08); wr(16'hB004, 8'h08);
    chk(0, 'h088, 0, 0, "R6"); chk(2, 'h004, 0, 0, "R6"); chk(1, 'h005, 0, 0, "R8");
    wr(16'hB000, 8'h09); chk(2, 'h004, 0, 0, "R6");
    wr(16'hB004, 8'h0C); chk(1, 'h005, 0, 0, "R6");
    wr(16'hB000, 8'h08); chk(0, 'h0C8, 0, 0, "R6"); chk(2, 'h004, 1, 0, "R6");
    chk(1, 'h005, 1, 1, "R7");
    wr(16'hC008, 8'h15); chk(3, 'h005, 1, 1, "R3");
    wr(16'hD004, 8'h1E); chk(4, 'h1E0, 0, 0, "R5");
    wr(16'hD008, 8'h1F); chk(5, 'h00F, 0, 0, "R2");
    wr(16'hE000, 8'h03); chk(6, 'h003, 0, 0, "R2");
    sweep("R8");
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    chk(4, 0, 0, 0, "R9"); chk(1, 0, 0, 0, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule